// File: doc/BRIEF.md
# Two-Lane Serial Bus Frame Receiver

This block sits behind a peripheral's bus transceiver and watches a serial I/O bus made of one bus clock line and two data lines. Every time the bus clock goes low while the receiver is idle, the levels on the two data lines tell it what kind of frame has started. The frame is a request-enable code, a data-channel-acknowledge code, or the start of a command or data word. The receiver reports the classification with a single-cycle pulse and a kind code.

After a word-start frame, the next eight bus clock pulses each carry two bits, one on each data line. These bits are shifted into a pair of 8-bit registers, which together form a 16-bit parallel word. When the eighth pulse has arrived, the block raises a one-cycle word strobe and goes back to idle. With the strobe it reports whether the word's device field equals the stored device code, so that later logic executes only commands meant for this peripheral.

All bus inputs pass through a multi-flop synchronizer into the system clock domain before any edge is detected. A direction input tells the receiver when the local controller is driving the bus, so that its own transfers are not taken as received frames.

Top module: `sio_frame_rx`

## Requirements
- R1: After reset, `frame_pulse`, `word_valid`, `dev_match` and `rx_busy` are 0 and `frame_kind` is 0.
- R2: In idle, a falling bus clock with both data lines high gives exactly one `frame_pulse` with `frame_kind` = 1 (request-enable).
- R3: In idle, a falling bus clock with data line 1 high and data line 2 low gives one `frame_pulse` with `frame_kind` = 2 (data-channel-acknowledge).
- R4: In idle, a falling bus clock with both data lines low gives one `frame_pulse` with `frame_kind` = 3 (word start) and sets `rx_busy`.
- R5: In idle, a falling bus clock with data line 1 low and data line 2 high gives no pulse, and the receiver stays idle.
- R6: In a word, the k-th falling bus clock (k = 0..7) after the start frame supplies word bit 2k from data line 1 and word bit 2k+1 from data line 2.
- R7: After the eighth data clock, `word_valid` is high for exactly one system cycle with the full word on `rx_word`, and the receiver returns to idle, so the next falling edge is classified again.
- R8: Falling bus clocks inside a word never produce a `frame_pulse`, whatever the data line levels are.
- R9: `dev_match` is high only together with `word_valid`, and it is high exactly when `rx_word[15:10]` equals `dev_code[5:0]` bit for bit.
- R10: While `bus_dir` is 1 (the local controller is driving), falling bus clocks are ignored. They start no frame and shift no data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk | input | 1 | Serial bus clock line, idles high |
| bus_d1 | input | 1 | Serial data line 1 (even word bits) |
| bus_d2 | input | 1 | Serial data line 2 (odd word bits) |
| bus_dir | input | 1 | 1 while the local controller drives the bus |
| dev_code | input | 6 | Stored device code compared with the word's device field |
| frame_pulse | output | 1 | One-cycle pulse when a frame is classified |
| frame_kind | output | 2 | Kind of the last frame: 1 request-enable, 2 acknowledge, 3 word start |
| word_valid | output | 1 | One-cycle strobe when a 16-bit word is complete |
| rx_word | output | 16 | Assembled parallel word |
| dev_match | output | 1 | Device field matches `dev_code`, valid with `word_valid` |
| rx_busy | output | 1 | Word reception in progress |

## Verification
The bench uses the default parameters: a two-stage synchronizer, 8-bit lanes, and a 6-bit device field at word bit 10. With these values every device field value can be reached by random words, and the bit counter wraps on each word. Random words are paired with random device codes, and half the words are forced to match, so both sides of the device compare are exercised. Directed cases cover the invalid data-line combination, frame-looking levels inside a word, and direction-blocked pulses both in idle and in the middle of a word.

// File: rtl/sio_rx_pkg.sv
package sio_rx_pkg;

    typedef enum logic [1:0] {
        KIND_NONE    = 2'd0,
        KIND_REQ_EN  = 2'd1,
        KIND_DCH_ACK = 2'd2,
        KIND_WORD    = 2'd3
    } frame_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WORD = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic clk;
        logic d1;
        logic d2;
    } bus_sample_t;

    localparam int BUS_LINES = $bits(bus_sample_t);

    // Frame type from the data line levels seen while the bus clock is low.
    function automatic frame_kind_e classify(input logic d1, input logic d2);
        frame_kind_e k;
        case ({d1, d2})
            2'b11:   k = KIND_REQ_EN;
            2'b10:   k = KIND_DCH_ACK;
            2'b00:   k = KIND_WORD;
            default: k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= RST_VAL;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= RST_VAL;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/sio_frame_ctl.sv
module sio_frame_ctl
    import sio_rx_pkg::*;
#(
    parameter int LANE_BITS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_sample_t smp,
    input  logic        bus_dir,
    output logic        shift_en,
    output logic        frame_pulse,
    output frame_kind_e frame_kind,
    output logic        word_valid,
    output logic        busy
);

    localparam int CNT_W = (LANE_BITS > 1) ? $clog2(LANE_BITS) : 1;
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(LANE_BITS - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] bit_cnt;
    logic             clk_prev;
    logic             fall;
    frame_kind_e      kind_now;

    assign fall     = clk_prev & ~smp.clk & ~bus_dir;
    assign kind_now = classify(smp.d1, smp.d2);
    assign shift_en = (state == ST_WORD) && fall;
    assign busy     = (state == ST_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_prev    <= 1'b1;
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            frame_pulse <= 1'b0;
            frame_kind  <= KIND_NONE;
            word_valid  <= 1'b0;
        end else begin
            clk_prev    <= smp.clk;
            frame_pulse <= 1'b0;
            word_valid  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (fall && kind_now != KIND_NONE) begin
                        frame_pulse <= 1'b1;
                        frame_kind  <= kind_now;
                        if (kind_now == KIND_WORD) begin
                            state   <= ST_WORD;
                            bit_cnt <= '0;
                        end
                    end
                end
                ST_WORD: begin
                    if (fall) begin
                        if (bit_cnt == LAST_CNT) begin
                            word_valid <= 1'b1;
                            state      <= ST_IDLE;
                            bit_cnt    <= '0;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: a classification pulse lasts a single cycle
    p_pulse_single_r2: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |=> !frame_pulse);

    // R2: a pulse always carries a real frame kind
    p_kind_known_r2: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> frame_kind != KIND_NONE);

    // R8: pulses only come from the idle state
    p_no_pulse_in_word_r8: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> $past(state) == ST_IDLE);

    // R7: word strobe is single-cycle and leaves the receiver idle
    p_word_single_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    p_word_idle_r7: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> state == ST_IDLE);

    // R10: a driven bus never yields a classification
    p_dir_block_r10: assert property (@(posedge clk) disable iff (rst)
        frame_pulse |-> !$past(bus_dir));

endmodule

// File: rtl/sio_dual_shift.sv
module sio_dual_shift #(
    parameter int LANES     = 2,
    parameter int LANE_BITS = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       shift_en,
    input  logic [LANES-1:0]           lane_in,
    output logic [LANES*LANE_BITS-1:0] word
);

    logic [LANE_BITS-1:0] sr [LANES];

    generate
        for (genvar l = 0; l < LANES; l++) begin : g_lane
            always_ff @(posedge clk) begin
                if (rst)           sr[l] <= '0;
                else if (shift_en) sr[l] <= {lane_in[l], sr[l][LANE_BITS-1:1]};
            end
            // lane l holds word bits l, l+LANES, l+2*LANES, ...
            for (genvar k = 0; k < LANE_BITS; k++) begin : g_bit
                assign word[k*LANES + l] = sr[l][k];
            end
        end
    endgenerate

    // R6: lane contents move only on a data clock
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(word));

endmodule

// File: rtl/sio_frame_rx.sv
module sio_frame_rx
    import sio_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LANE_BITS   = 8,
    parameter int DEV_BITS    = 6,
    parameter int DEV_LSB     = 10
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_clk,
    input  logic                   bus_d1,
    input  logic                   bus_d2,
    input  logic                   bus_dir,
    input  logic [DEV_BITS-1:0]    dev_code,
    output logic                   frame_pulse,
    output logic [1:0]             frame_kind,
    output logic                   word_valid,
    output logic [2*LANE_BITS-1:0] rx_word,
    output logic                   dev_match,
    output logic                   rx_busy
);

    localparam int WORD_BITS = 2 * LANE_BITS;

    logic [BUS_LINES-1:0] sync_out;
    bus_sample_t          smp;
    logic                 shift_en;
    frame_kind_e          kind_q;

    sio_sync #(
        .WIDTH   (BUS_LINES),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({BUS_LINES{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({bus_clk, bus_d1, bus_d2}),
        .dout (sync_out)
    );

    assign smp = bus_sample_t'(sync_out);

    sio_frame_ctl #(
        .LANE_BITS (LANE_BITS)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .smp         (smp),
        .bus_dir     (bus_dir),
        .shift_en    (shift_en),
        .frame_pulse (frame_pulse),
        .frame_kind  (kind_q),
        .word_valid  (word_valid),
        .busy        (rx_busy)
    );

    sio_dual_shift #(
        .LANES     (2),
        .LANE_BITS (LANE_BITS)
    ) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .lane_in  ({smp.d2, smp.d1}),
        .word     (rx_word)
    );

    assign frame_kind = kind_q;
    assign dev_match  = word_valid && (rx_word[DEV_LSB +: DEV_BITS] == dev_code);

    initial begin
        p_field_fits_r9: assert (DEV_LSB + DEV_BITS <= WORD_BITS);
    end

    // R9: a match indication only accompanies a finished word
    p_match_with_word_r9: assert property (@(posedge clk) disable iff (rst)
        dev_match |-> word_valid);

    // R4: a word-start classification puts the receiver in reception
    p_start_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (frame_pulse && frame_kind == 2'd3) |-> rx_busy);

endmodule

// File: tb/test_sio_frame_rx.sv
module test_sio_frame_rx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_clk = 1'b1;
    logic        bus_d1 = 1'b1;
    logic        bus_d2 = 1'b1;
    logic        bus_dir = 1'b0;
    logic [5:0]  dev_code = 6'd0;
    logic        frame_pulse;
    logic [1:0]  frame_kind;
    logic        word_valid;
    logic [15:0] rx_word;
    logic        dev_match;
    logic        rx_busy;

    int total = 0;
    int bad   = 0;
    int fp_cnt = 0;
    int wv_cnt = 0;
    logic [1:0]  last_kind = 2'd0;
    logic [15:0] last_word = 16'd0;
    logic        last_match = 1'b0;

    always #4 clk = ~clk;

    sio_frame_rx i_sio_frame_rx (
        .clk (clk), .rst (rst),
        .bus_clk (bus_clk), .bus_d1 (bus_d1), .bus_d2 (bus_d2),
        .bus_dir (bus_dir), .dev_code (dev_code),
        .frame_pulse (frame_pulse), .frame_kind (frame_kind),
        .word_valid (word_valid), .rx_word (rx_word),
        .dev_match (dev_match), .rx_busy (rx_busy)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_pulse) begin
                fp_cnt++;
                last_kind = frame_kind;
            end
            if (word_valid) begin
                wv_cnt++;
                last_word  = rx_word;
                last_match = dev_match;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_pulse(input logic d1, input logic d2);
        bus_d1 = d1;
        bus_d2 = d2;
        cyc(3);
        bus_clk = 1'b0;
        cyc(4);
        bus_clk = 1'b1;
        cyc(4);
    endtask

    function automatic logic exp_match(input logic [15:0] w, input logic [5:0] code);
        logic m = 1'b1;
        for (int j = 0; j < 6; j++)
            if (w[10 + j] != code[j]) m = 1'b0;
        return m;
    endfunction

    task automatic send_word(input logic [15:0] w);
        int f0, w0;
        f0 = fp_cnt;
        w0 = wv_cnt;
        bus_pulse(1'b0, 1'b0);
        chk(fp_cnt == f0 + 1 && last_kind == 2'd3, "R4 start kind", last_kind, 3);
        chk(rx_busy == 1'b1, "R4 busy", rx_busy, 1);
        for (int k = 0; k < 8; k++) bus_pulse(w[2*k], w[2*k+1]);
        chk(fp_cnt == f0 + 1, "R8 no pulse in word", fp_cnt - f0, 1);
        chk(wv_cnt == w0 + 1, "R7 one strobe", wv_cnt - w0, 1);
        chk(last_word == w, "R6 word", last_word, w);
        chk(last_match == exp_match(w, dev_code), "R9 match", last_match, exp_match(w, dev_code));
        chk(rx_busy == 1'b0, "R7 idle after", rx_busy, 0);
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        int f0, w0;
        void'($urandom(32'd4711));
        cyc(5);
        chk(frame_pulse == 0 && word_valid == 0 && dev_match == 0 && rx_busy == 0 && frame_kind == 0,
            "R1 reset", {frame_pulse, word_valid, dev_match, rx_busy, frame_kind}, 0);
        @(negedge clk);
        rst = 1'b0;
        cyc(4);

        // R2 / R3
        f0 = fp_cnt;
        bus_pulse(1'b1, 1'b1);
        chk(fp_cnt == f0 + 1 && last_kind == 2'd1, "R2 request-enable", last_kind, 1);
        f0 = fp_cnt;
        bus_pulse(1'b1, 1'b0);
        chk(fp_cnt == f0 + 1 && last_kind == 2'd2, "R3 acknowledge", last_kind, 2);

        // R5 invalid combination
        f0 = fp_cnt;
        bus_pulse(1'b0, 1'b1);
        chk(fp_cnt == f0, "R5 no pulse", fp_cnt - f0, 0);
        chk(rx_busy == 1'b0, "R5 idle", rx_busy, 0);

        // R10 blocked in idle
        bus_dir = 1'b1;
        f0 = fp_cnt;
        bus_pulse(1'b0, 1'b0);
        chk(fp_cnt == f0 && rx_busy == 0, "R10 idle blocked", fp_cnt - f0, 0);
        bus_dir = 1'b0;

        // directed words with frame-like data levels (R8)
        dev_code = 6'h3F;
        send_word(16'hFFFF);
        dev_code = 6'h00;
        send_word(16'h0000);
        send_word(16'hAAAA);
        dev_code = 6'h15;
        send_word(16'h5555);

        // R10 blocked in the middle of a word
        w = 16'hC3A5;
        w0 = wv_cnt;
        bus_pulse(1'b0, 1'b0);
        for (int k = 0; k < 3; k++) bus_pulse(w[2*k], w[2*k+1]);
        bus_dir = 1'b1;
        bus_pulse(~w[6], ~w[7]);
        bus_dir = 1'b0;
        for (int k = 3; k < 8; k++) bus_pulse(w[2*k], w[2*k+1]);
        chk(wv_cnt == w0 + 1 && last_word == w, "R10 mid-word blocked", last_word, w);

        // R7 next frame after a word classified again
        f0 = fp_cnt;
        bus_pulse(1'b1, 1'b0);
        chk(fp_cnt == f0 + 1 && last_kind == 2'd2, "R7 classify after word", last_kind, 2);

        // random words, half forced to match
        for (int n = 0; n < 40; n++) begin
            dev_code = 6'($urandom);
            w = 16'($urandom);
            if (n % 2 == 0) w[15:10] = dev_code;
            send_word(w);
            if ($urandom % 3 == 0) begin
                f0 = fp_cnt;
                bus_pulse(1'b1, 1'b1);
                chk(fp_cnt == f0 + 1 && last_kind == 2'd1, "R2 random", last_kind, 1);
            end
        end

        cyc(5);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule